// File: doc/BRIEF.md
# Memory-Mapped Real-Time Timer

This block is a real-time clock peripheral that sits on a processor's register bus. It keeps a 64-bit time counter that advances by one on every clock in which a tick-enable input is high. It also keeps a 64-bit compare value. A dedicated interrupt output goes to the core and asserts once the time counter reaches or passes the compare value. The interrupt stays asserted until software rewrites the compare value.

Software reaches both 64-bit registers through a 32-bit register bus. Each register appears as a low word and a high word. A request is a single cycle: `bus_valid` high, with `bus_we` choosing write or read. Read data appears on `bus_rdata` on the cycle after the request. A write replaces only the 32-bit half it addresses. To rearm the timer, software writes a new compare value, and either half of that write clears the pending interrupt.

Top module: `rt_timer`

## Requirements
- R1: After reset, the time counter is 0, the compare register is all ones, `timer_irq` is low and `bus_rdata` is 0.
- R2: When the time counter is greater than or equal to the compare register, compared as unsigned 64-bit values, `timer_irq` rises at the next clock edge. This holds unless that cycle writes the compare register.
- R3: Once high, `timer_irq` stays high even if the time counter or the compare register later falls out of the set condition, until a compare write occurs.
- R4: A write to either compare half (offset 0x8 or 0xC) drives `timer_irq` low after that edge. The condition is evaluated again from the following edge, so the interrupt returns one cycle later if time is still greater than or equal to compare.
- R5: The time counter increments by one on each edge where `tick_en` is high and no time write occurs. It holds its value when `tick_en` is low.
- R6: A write to a time half loads the written value into that half. In that cycle the counter does not increment, even if `tick_en` is high.
- R7: Writing one 32-bit half of the time or compare register leaves the other half unchanged.
- R8: Byte offsets map as follows: 0x0 is time bits 31:0, 0x4 is time bits 63:32, 0x8 is compare bits 31:0, and 0xC is compare bits 63:32. Read data for a request appears on `bus_rdata` on the next cycle. `bus_rdata` is 0 in cycles with no read.
- R9: A read of any other offset returns 0. A write to any other offset changes no register.
- R10: The counter carries from bit 31 into bit 32, so incrementing a time of low word 0xFFFFFFFF advances the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the time counter when high |
| bus_valid | input | 1 | Request strobe for the register bus |
| bus_we | input | 1 | Selects a write (1) or a read (0) |
| bus_addr | input | ADDR_W | Byte offset of the addressed register |
| bus_wdata | input | 32 | Data to write |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| timer_irq | output | 1 | Sticky timer interrupt to the core |

## Verification
The bench builds the block with `ADDR_W` set to 6. This leaves offsets from 0x10 to 0x3F, and misaligned offsets such as 0x5, as unmapped addresses that the bench can read and write to exercise R9. The bench sets the time counter close to the carry boundary and close to the unsigned sign bit. This reaches the word carry and the top-bit comparison within a few ticks instead of 2^32 cycles.

// File: rtl/rt_timer.sv
module rt_timer #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              timer_irq
);
  localparam int TIME_W = 64;
  localparam int WORD_W = 32;
  localparam logic [ADDR_W-1:0] OFS_TLO = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_THI = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_CLO = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFS_CHI = ADDR_W'(4'hC);

  logic [TIME_W-1:0] time_q, cmp_q;
  logic              pend_q;
  logic [WORD_W-1:0] rdata_q;

  wire wr      = bus_valid & bus_we;
  wire rd      = bus_valid & ~bus_we;
  wire wr_tlo  = wr & (bus_addr == OFS_TLO);
  wire wr_thi  = wr & (bus_addr == OFS_THI);
  wire wr_clo  = wr & (bus_addr == OFS_CLO);
  wire wr_chi  = wr & (bus_addr == OFS_CHI);
  wire wr_time = wr_tlo | wr_thi;
  wire wr_cmp  = wr_clo | wr_chi;
  wire hit     = ~(time_q < cmp_q);

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      OFS_TLO: rd_mux = time_q[WORD_W-1:0];
      OFS_THI: rd_mux = time_q[TIME_W-1:WORD_W];
      OFS_CLO: rd_mux = cmp_q[WORD_W-1:0];
      OFS_CHI: rd_mux = cmp_q[TIME_W-1:WORD_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (wr_tlo) begin
      time_q[WORD_W-1:0] <= bus_wdata;
    end else if (wr_thi) begin
      time_q[TIME_W-1:WORD_W] <= bus_wdata;
    end else if (tick_en) begin
      time_q <= time_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else if (wr_clo) begin
      cmp_q[WORD_W-1:0] <= bus_wdata;
    end else if (wr_chi) begin
      cmp_q[TIME_W-1:WORD_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (wr_cmp) pend_q <= 1'b0;
    else if (hit)    pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
  assign timer_irq = pend_q;
endmodule

module rt_timer_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              timer_irq,
  input logic [63:0]       time_q,
  input logic [63:0]       cmp_q
);
  wire cmp_wr  = bus_valid && bus_we && (bus_addr == ADDR_W'(8) || bus_addr == ADDR_W'(12));
  wire time_wr = bus_valid && bus_we && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4));
  wire lo_wr   = bus_valid && bus_we && (bus_addr == ADDR_W'(0));
  wire unmap_rd = bus_valid && !bus_we && bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(4)
                  && bus_addr != ADDR_W'(8) && bus_addr != ADDR_W'(12);

  assert_irq_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q >= cmp_q && !cmp_wr) |=> timer_irq);
  assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq && !cmp_wr) |=> timer_irq);
  assert_cmp_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !timer_irq);
  assert_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_wr) |=> time_q == $past(time_q) + 64'd1);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !time_wr) |=> $stable(time_q));
  assert_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> time_q[63:32] == $past(time_q[63:32]));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_rd |=> bus_rdata == 32'd0);
endmodule

bind rt_timer rt_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .timer_irq(timer_irq), .time_q(time_q), .cmp_q(cmp_q)
);

// File: tb/rt_timer_test.sv
module rt_timer_test;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          timer_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  rt_timer #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq", {31'd0, timer_irq}, 32'd0);
    check("R1 rdata idle", bus_rdata, 32'd0);
    rd(6'h0, rv); check("R1 time lo", rv, 32'd0);
    rd(6'h4, rv); check("R1 time hi", rv, 32'd0);
    rd(6'h8, rv); check("R1 cmp lo", rv, 32'hFFFFFFFF);
    rd(6'hC, rv); check("R1 cmp hi", rv, 32'hFFFFFFFF);
    @(negedge clk); check("R8 rdata zero when idle", bus_rdata, 32'd0);
  endtask

  task automatic t_tick;
    wr(6'h0, 32'd0); wr(6'h4, 32'd0);
    ticks(7);
    rd(6'h0, rv); check("R5 count after 7 ticks", rv, 32'd7);
    repeat (3) @(negedge clk);
    rd(6'h0, rv); check("R5 hold without tick", rv, 32'd7);
  endtask

  task automatic t_carry;
    wr(6'h0, 32'hFFFFFFFE); wr(6'h4, 32'd5);
    ticks(3);
    rd(6'h4, rv); check("R10 carry hi", rv, 32'd6);
    rd(6'h0, rv); check("R10 carry lo", rv, 32'd1);
  endtask

  task automatic t_priority;
    tick_en = 1'b1;
    wr(6'h0, 32'd100);
    tick_en = 1'b0;
    rd(6'h0, rv); check("R6 write beats tick", rv, 32'd100);
    rd(6'h4, rv); check("R7 time hi kept", rv, 32'd6);
  endtask

  task automatic t_half;
    wr(6'h8, 32'h0000_1234);
    rd(6'hC, rv); check("R7 cmp hi kept", rv, 32'hFFFFFFFF);
    rd(6'h8, rv); check("R8 cmp lo map", rv, 32'h0000_1234);
  endtask

  task automatic t_irq;
    wr(6'h0, 32'd0); wr(6'h4, 32'd0);
    wr(6'hC, 32'd0); wr(6'h8, 32'd10);
    @(negedge clk); check("R2 no irq below", {31'd0, timer_irq}, 32'd0);
    ticks(9);
    @(negedge clk); check("R2 no irq at 9", {31'd0, timer_irq}, 32'd0);
    ticks(1);
    check("R2 not yet same cycle", {31'd0, timer_irq}, 32'd0);
    @(negedge clk); check("R2 irq at equal", {31'd0, timer_irq}, 32'd1);
    wr(6'h0, 32'd0);
    repeat (2) @(negedge clk);
    check("R3 sticky after time drop", {31'd0, timer_irq}, 32'd1);
    wr(6'hC, 32'd1);
    check("R4 cleared by cmp hi write", {31'd0, timer_irq}, 32'd0);
    repeat (2) @(negedge clk);
    check("R4 stays clear", {31'd0, timer_irq}, 32'd0);
    wr(6'h0, 32'd50);
    wr(6'hC, 32'd0);
    check("R4 clear in write cycle", {31'd0, timer_irq}, 32'd0);
    @(negedge clk); check("R4 re-evaluated next cycle", {31'd0, timer_irq}, 32'd1);
    wr(6'h8, 32'd60);
    check("R4 cleared by cmp lo write", {31'd0, timer_irq}, 32'd0);
    @(negedge clk); check("R4 stays low when below", {31'd0, timer_irq}, 32'd0);
  endtask

  task automatic t_unsigned;
    wr(6'hC, 32'h8000_0000); wr(6'h8, 32'd0);
    wr(6'h4, 32'h7FFF_FFFF); wr(6'h0, 32'hFFFF_FFFF);
    @(negedge clk); check("R2 unsigned below", {31'd0, timer_irq}, 32'd0);
    ticks(1);
    @(negedge clk); check("R2 unsigned top bit", {31'd0, timer_irq}, 32'd1);
    rd(6'h4, rv); check("R10 carry to top bit", rv, 32'h8000_0000);
  endtask

  task automatic t_unmapped;
    wr(6'h0, 32'hA5A5_0001); wr(6'h4, 32'h0000_0002);
    wr(6'h8, 32'h0000_0003); wr(6'hC, 32'h0000_0004);
    rd(6'h10, rv); check("R9 read 0x10", rv, 32'd0);
    rd(6'h05, rv); check("R9 read 0x05", rv, 32'd0);
    rd(6'h3C, rv); check("R9 read 0x3C", rv, 32'd0);
    wr(6'h14, 32'hDEAD_BEEF); wr(6'h09, 32'hDEAD_BEEF);
    rd(6'h0, rv); check("R9 time lo untouched", rv, 32'hA5A5_0001);
    rd(6'h4, rv); check("R9 time hi untouched", rv, 32'h0000_0002);
    rd(6'h8, rv); check("R9 cmp lo untouched", rv, 32'h0000_0003);
    rd(6'hC, rv); check("R9 cmp hi untouched", rv, 32'h0000_0004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_tick;
    t_carry;
    t_priority;
    t_half;
    t_irq;
    t_unsigned;
    t_unmapped;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule